// File: doc/BRIEF.md
# Selectable-Source Down-Counting Tick Timer

This block is a periodic tick timer for a processor subsystem. A 24-bit counter counts down by one on each selected tick. The tick comes from one of two places. One is a single-cycle reference enable pulse that is synchronous to the core clock. The other is the core clock itself, which gives one tick per cycle. When the counter sits at zero for one tick, it takes the programmed reload value. A count of R therefore repeats every R+1 ticks.

Each step from one to zero latches a count flag. An interrupt-enable bit can route that flag to a level interrupt output. Software uses a small word-wide register port with separate write and read strobes. Read data is registered, so it appears one cycle after the read strobe.

Top module: `sys_tick_timer`

## Requirements
- R1: While control bit 0 (run) is clear, the counter value does not change, whatever the tick inputs do.
- R2: Control bit 2 selects the tick source. 0 counts only on cycles where `ref_tick_i` is high; 1 counts on every clock cycle and ignores `ref_tick_i`.
- R3: On a tick, a nonzero count decrements by one. A count of zero takes the reload value on its next tick, so a reload of R gives a period of R+1 ticks.
- R4: After run changes from 0 to 1, the first tick loads the reload value whatever the count held. Counting down continues from there.
- R5: Any write to address 2 forces the count to zero, whatever data is written, and clears the count flag. While running, the next tick reloads and then decrements follow.
- R6: The count flag is control bit 16. It is set by a tick that moves the count from 1 to 0, and a read of address 0 returns it and clears it.
- R7: `irq_o` is high exactly while the count flag is set and control bit 1 (interrupt enable) is set.
- R8: With a reload of zero the count stays at zero and the count flag is never set.
- R9: The register map is: address 0 is control/status, address 1 is reload (24 bits; the upper read bits are zero), address 2 is the current value, and address 3 reads zero. `rdata_o` holds the selected value from the clock edge that samples `rd_en_i`.
- R10: Reset clears control, reload, count, flag, `rdata_o` and `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick_i | input | 1 | Reference tick enable, one cycle wide |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench sweeps several reload values, including zero and one, on the core-clock source and checks every read against R minus the tick index modulo R+1. A design that reloads straight from one, or that skips the tick spent at zero, fails this sweep by one at every wrap. The bench also clears the count in mid-run and expects zero, then the reload, then a decrement. A timer that restarts or loads the written data fails there. On the reference source, the bench first stops the counter at a nonzero value, then re-enables it and sends one pulse; a design that decrements instead of loading is caught. Further checks confirm that a zero reload never raises the flag and that the interrupt follows the flag and its enable bit in the same cycle.

// File: rtl/stt_pkg.sv
package stt_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL    = 2'd0,
    REG_RELOAD  = 2'd1,
    REG_CURRENT = 2'd2,
    REG_SPARE   = 2'd3
  } reg_sel_e;

  localparam int unsigned BIT_RUN      = 0;
  localparam int unsigned BIT_IRQ_EN   = 1;
  localparam int unsigned BIT_SRC_CORE = 2;
  localparam int unsigned BIT_FLAG     = 16;

  typedef struct packed {
    logic src_core;
    logic irq_en;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/stt_tick_sel.sv
module stt_tick_sel (
  input  logic run_i,
  input  logic src_core_i,
  input  logic ref_tick_i,
  output logic tick_o
);
  logic src_tick;

  // Source mux: core clock ticks every cycle, reference only on its pulse
  always_comb begin
    if (src_core_i) src_tick = 1'b1;
    else            src_tick = ref_tick_i;
  end

  assign tick_o = run_i & src_tick;
endmodule

// File: rtl/stt_counter.sv
module stt_counter #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic             start_i,
  input  logic             rd_clr_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] count_o,
  output logic             flag_o
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] count_q;
  logic             fresh_q;
  logic             flag_q;
  logic             step;
  logic             hit_zero;

  assign step     = tick_i && !clr_i;
  assign hit_zero = step && !fresh_q && (count_q == CNT_ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      fresh_q <= 1'b0;
    end else if (clr_i) begin
      count_q <= '0;
      fresh_q <= 1'b0;
    end else if (step) begin
      fresh_q <= 1'b0;
      if (fresh_q || count_q == '0) count_q <= reload_i;
      else                          count_q <= count_q - CNT_ONE;
    end else if (start_i) begin
      fresh_q <= 1'b1;
    end
  end

  // Flag: clear-by-write first, then a new event beats a clearing read
  always_ff @(posedge clk) begin
    if (rst)           flag_q <= 1'b0;
    else if (clr_i)    flag_q <= 1'b0;
    else if (hit_zero) flag_q <= 1'b1;
    else if (rd_clr_i) flag_q <= 1'b0;
  end

  assign count_o = count_q;
  assign flag_o  = flag_q;

  // R1
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !clr_i) |=> $stable(count_q));

  // R3
  reload_after_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !fresh_q && count_q == '0) |=> (count_q == $past(reload_i)));

  // R4
  first_tick_loads_chk: assert property (@(posedge clk) disable iff (rst)
    (step && fresh_q) |=> (count_q == $past(reload_i)));

  // R5
  clear_write_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (count_q == '0 && !flag_q));

  // R6
  flag_on_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    hit_zero |=> flag_q);
endmodule

// File: rtl/stt_regs.sv
module stt_regs
  import stt_pkg::*;
#(
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              flag_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic              start_o,
  output logic              clr_o,
  output logic              rd_ctrl_o,
  output logic [DATA_W-1:0] rdata_o
);
  reg_sel_e          sel;
  ctrl_t             ctrl_q;
  logic [CNT_W-1:0]  reload_q;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;
  logic              unused_wdata;

  assign sel          = reg_sel_e'(addr_i);
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      reload_q <= '0;
    end else if (wr_en_i) begin
      if (sel == REG_CTRL) begin
        ctrl_q.run      <= wdata_i[BIT_RUN];
        ctrl_q.irq_en   <= wdata_i[BIT_IRQ_EN];
        ctrl_q.src_core <= wdata_i[BIT_SRC_CORE];
      end
      if (sel == REG_RELOAD) reload_q <= wdata_i[CNT_W-1:0];
    end
  end

  assign start_o   = wr_en_i && (sel == REG_CTRL) && wdata_i[BIT_RUN] && !ctrl_q.run;
  assign clr_o     = wr_en_i && (sel == REG_CURRENT);
  assign rd_ctrl_o = rd_en_i && (sel == REG_CTRL);

  always_comb begin
    rd_mux = '0;
    case (sel)
      REG_CTRL: begin
        rd_mux[BIT_RUN]      = ctrl_q.run;
        rd_mux[BIT_IRQ_EN]   = ctrl_q.irq_en;
        rd_mux[BIT_SRC_CORE] = ctrl_q.src_core;
        rd_mux[BIT_FLAG]     = flag_i;
      end
      REG_RELOAD:  rd_mux[CNT_W-1:0] = reload_q;
      REG_CURRENT: rd_mux[CNT_W-1:0] = count_i;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end

  assign ctrl_o   = ctrl_q;
  assign reload_o = reload_q;
  assign rdata_o  = rdata_q;

  // R9
  spare_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && sel == REG_SPARE) |=> (rdata_o == '0));
endmodule

// File: rtl/sys_tick_timer.sv
module sys_tick_timer
  import stt_pkg::*;
#(
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_tick_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] count;
  logic             flag;
  logic             start;
  logic             clr;
  logic             rd_ctrl;
  logic             tick;

  stt_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en_i   (wr_en_i),
    .rd_en_i   (rd_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .count_i   (count),
    .flag_i    (flag),
    .ctrl_o    (ctrl),
    .reload_o  (reload),
    .start_o   (start),
    .clr_o     (clr),
    .rd_ctrl_o (rd_ctrl),
    .rdata_o   (rdata_o)
  );

  stt_tick_sel u_tick (
    .run_i      (ctrl.run),
    .src_core_i (ctrl.src_core),
    .ref_tick_i (ref_tick_i),
    .tick_o     (tick)
  );

  stt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .tick_i   (tick),
    .clr_i    (clr),
    .start_i  (start),
    .rd_clr_i (rd_ctrl),
    .reload_i (reload),
    .count_o  (count),
    .flag_o   (flag)
  );

  // Both operands are flops, so the interrupt tracks the flag in the same cycle
  assign irq_o = flag & ctrl.irq_en;
endmodule

// File: tb/sys_tick_timer_test.sv
module sys_tick_timer_test;
  localparam logic [1:0] A_CTRL = 2'd0, A_RLD = 2'd1, A_CUR = 2'd2, A_SPR = 2'd3;
  localparam logic [31:0] RUN = 32'h1, IE = 32'h2, CORE = 32'h4, FLAG = 32'h1_0000;

  logic clk = 1'b0, rst = 1'b1, ref_tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = 32'd0;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0, errors = 0;

  sys_tick_timer uut (
    .clk(clk), .rst(rst), .ref_tick_i(ref_tick), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  always #10 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Tasks start and end at a falling edge
  task automatic wr(logic [1:0] a, logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic pulse();
    ref_tick = 1'b1;
    @(negedge clk);
    ref_tick = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    int rl[6] = '{0, 1, 2, 3, 5, 7};
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R10 reset state
    check("R10 rdata", rdata, 32'h0);
    check("R10 irq", {31'd0, irq}, 32'h0);
    rd(A_CTRL, v); check("R10 ctrl", v, 32'h0);
    rd(A_RLD, v);  check("R10 reload", v, 32'h0);
    rd(A_CUR, v);  check("R10 count", v, 32'h0);

    // R9 map: reload width and spare address
    wr(A_RLD, 32'hFFFF_FFFF);
    rd(A_RLD, v); check("R9 reload width", v, 32'h00FF_FFFF);
    rd(A_SPR, v); check("R9 spare", v, 32'h0);

    // R3 R8 sweep on core clock
    foreach (rl[i]) begin
      int r = rl[i];
      wr(A_CTRL, 32'h0);
      wr(A_RLD, r);
      wr(A_CUR, 32'h0);
      wr(A_CTRL, RUN | CORE);
      for (int k = 1; k <= 2 * (r + 1) + 3; k++) begin
        logic [31:0] e;
        e = (k == 1) ? 32'd0 : 32'(r - ((k - 2) % (r + 1)));
        rd(A_CUR, v);
        check(r == 0 ? "R8 parked count" : "R3 count sequence", v, e);
      end
      wr(A_CTRL, 32'h0);
      rd(A_CTRL, v); check(r == 0 ? "R8 no flag" : "R6 flag set", v, (r > 0) ? FLAG : 32'h0);
      rd(A_CTRL, v); check("R6 flag cleared by read", v, 32'h0);
      rd(A_CUR, v); repeat (5) @(negedge clk); rd(A_CUR, v2);
      check("R1 stopped holds", v2, v);
    end

    // R7 interrupt follows flag and enable
    wr(A_RLD, 32'd3);
    wr(A_CUR, 32'h0);
    wr(A_CTRL, RUN | IE | CORE);
    for (int k = 0; k <= 4; k++) begin
      check("R7 irq rise", {31'd0, irq}, (k >= 4) ? 32'h1 : 32'h0);
      if (k < 4) @(negedge clk);
    end
    rd(A_CTRL, v); check("R6 flag read", v, FLAG | RUN | IE | CORE);
    check("R7 irq cleared by read", {31'd0, irq}, 32'h0);
    @(negedge clk); @(negedge clk);
    check("R7 irq low", {31'd0, irq}, 32'h0);
    @(negedge clk);
    check("R7 irq again", {31'd0, irq}, 32'h1);
    wr(A_CUR, 32'h0);
    check("R5 write clears flag irq", {31'd0, irq}, 32'h0);
    wr(A_CTRL, RUN | CORE);
    for (int k = 0; k < 10; k++) begin
      check("R7 masked irq", {31'd0, irq}, 32'h0);
      @(negedge clk);
    end
    rd(A_CTRL, v); check("R7 flag without irq", v, FLAG | RUN | CORE);

    // R5 clear while running does not restart
    wr(A_CTRL, 32'h0);
    wr(A_RLD, 32'd5);
    wr(A_CUR, 32'h0);
    wr(A_CTRL, RUN | CORE);
    repeat (3) @(negedge clk);
    wr(A_CUR, 32'h00FF_FFFF);
    rd(A_CUR, v); check("R5 cleared", v, 32'd0);
    rd(A_CUR, v); check("R5 reload after clear", v, 32'd5);
    rd(A_CUR, v); check("R5 decrement after clear", v, 32'd4);
    rd(A_CTRL, v); check("R5 clear not a wrap", v, RUN | CORE);
    wr(A_CTRL, 32'h0);
    rd(A_CUR, v); check("R1 stop value", v, 32'd1);

    // R2 R4 reference source
    wr(A_RLD, 32'd9);
    wr(A_CTRL, RUN);
    repeat (5) @(negedge clk);
    rd(A_CUR, v); check("R2 no ref no count", v, 32'd1);
    pulse();
    rd(A_CUR, v); check("R4 first tick loads", v, 32'd9);
    pulse(); pulse();
    rd(A_CUR, v); check("R2 ref counts", v, 32'd7);
    wr(A_CTRL, 32'h0);
    pulse(); pulse(); pulse();
    rd(A_CUR, v); check("R1 ref ignored when stopped", v, 32'd7);
    rd(A_CTRL, v); check("R6 no flag", v, 32'h0);

    // R3 wrap on reference ticks
    wr(A_RLD, 32'd2);
    wr(A_CUR, 32'h0);
    wr(A_CTRL, RUN);
    pulse(); rd(A_CUR, v); check("R4 ref load", v, 32'd2);
    pulse(); rd(A_CUR, v); check("R3 ref dec", v, 32'd1);
    pulse(); rd(A_CUR, v); check("R3 ref zero", v, 32'd0);
    pulse(); rd(A_CUR, v); check("R3 ref reload", v, 32'd2);
    rd(A_CTRL, v); check("R6 ref flag", v, FLAG | RUN);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule